// File: doc/BRIEF.md
# Configuration Image Loader

This block copies a stored partial configuration image out of system memory and into a 32-bit configuration port, with no help from the CPU. A small table of four descriptors gives each reconfigurable module a word-aligned start address and a length in words. Software or a controller fills the table through a simple write port. A start request then names a module index, and the loader fetches that image over a simplified AHB-style read-only bus.

The fetched words go into a buffer. The buffer drains into the configuration port through a valid/ready handshake, one word per clock whenever the port is ready. Bus reads are grouped into incrementing bursts. A burst is launched only when the buffer is certain to have space for all of its beats. When the last word has been accepted by the port, a one-cycle done pulse is raised. An error response on the bus ends the copy early. In that case the error flag is set and done is still pulsed, so the controller waiting on done is never stranded.

Top module: `cfg_image_loader`

## Requirements
- R1: A table write with `tbl_we_i` high stores a start address (its two low bits forced to zero) and a length for entry `tbl_idx_i`. A later accepted start on that index delivers exactly that many words to the configuration port, in increasing address order, each equal to the memory word at its address.
- R2: Every bus transfer is a word read. A burst begins with `htrans_o` = 2'b10 (first beat) and continues with 2'b11 (later beats), the address rising by 4 per beat. A full burst carries 8 beats and reports `hburst_o` = 3'b101. A shorter final burst carries the remaining beats and reports 3'b001. `htrans_o` = 2'b00 means no transfer.
- R3: A new burst starts only when buffer occupancy plus beats already requested leaves room for a whole burst, so the buffer never overflows. With the configuration port held not ready, exactly 16 beats are accepted on the bus for an image of at least 16 words, and then reading stops.
- R4: While `cfg_valid_o` is high and `cfg_ready_i` is low, the valid and data outputs hold. When the buffer is full and the port stays ready, one word is delivered on every clock.
- R5: `done_o` is a single-cycle pulse in the cycle after the last word's handshake. `busy_o` is low from that cycle on.
- R6: A start on an entry whose length is zero pulses `done_o` in the next cycle, with no bus transfer and without raising `busy_o`.
- R7: A start request that arrives while `busy_o` is high is ignored. The running copy completes with its own image and produces exactly one done pulse.
- R8: A data beat completing with `hready_i` and `hresp_i` both high aborts the copy. The same cycle `err_o` goes high, `done_o` is pulsed, and the buffer is emptied. After that, no bus transfer is issued and `cfg_valid_o` stays low. `err_o` clears when the next start is accepted.
- R9: `hready_i` low stalls the bus: the address, transfer type and pending data beat hold. Delivered data is unaffected by any pattern of wait states.
- R10: After reset, `busy_o`, `done_o`, `err_o` and `cfg_valid_o` are low and `htrans_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tbl_we_i | input | 1 | Descriptor table write enable |
| tbl_idx_i | input | 2 | Descriptor entry to write |
| tbl_base_i | input | 32 | Image start byte address |
| tbl_len_i | input | 16 | Image length in words |
| start_i | input | 1 | Start request |
| start_idx_i | input | 2 | Descriptor entry selected by the start |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last copy ended on a bus error |
| haddr_o | output | 32 | Bus byte address |
| htrans_o | output | 2 | Bus transfer type |
| hburst_o | output | 3 | Bus burst type |
| hrdata_i | input | 32 | Bus read data |
| hready_i | input | 1 | Bus transfer complete |
| hresp_i | input | 1 | Bus error response |
| cfg_valid_o | output | 1 | Configuration word valid |
| cfg_ready_i | input | 1 | Configuration port ready |
| cfg_data_o | output | 32 | Configuration word |

## Verification
Images are loaded under several patterns, and each pattern separates a different fault:
- An always-ready bus and port with a length of 20 exposes the split between full and short bursts and the exact word count.
- Random wait states on both sides with a length of 37 show that neither stall corrupts or reorders data.
- Holding the port not ready with a length of 40 shows whether the reservation logic stops at the buffer size, and then whether the full buffer drains at one word per cycle.
- A zero-length entry, a start issued mid-copy, an error on the eleventh beat, and a rewritten descriptor respectively separate the immediate-done path, ignored starts, the abort-and-flush path, and stale table contents.

// File: rtl/cil_pkg.sv
package cil_pkg;

   typedef enum logic [1:0] {
      HT_IDLE   = 2'b00,
      HT_BUSY   = 2'b01,
      HT_NONSEQ = 2'b10,
      HT_SEQ    = 2'b11
   } htrans_e;

   localparam logic [2:0] HB_INCR = 3'b001;

   typedef enum logic {
      LD_IDLE,
      LD_RUN
   } ld_state_e;

   // Fixed-length incrementing burst code for a given beat count,
   // unspecified-length incrementing burst otherwise.
   function automatic logic [2:0] burst_code(int beats);
      case (beats)
         4:       return 3'b011;
         8:       return 3'b101;
         16:      return 3'b111;
         default: return HB_INCR;
      endcase
   endfunction

endpackage

// File: rtl/cil_desc_table.sv
module cil_desc_table #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_base_i,
   input  logic [LEN_W-1:0]  wr_len_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_base_o,
   output logic [LEN_W-1:0]  rd_len_o
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

   logic [ADDR_W-1:0] base_q [ENTRIES];
   logic [LEN_W-1:0]  len_q  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            base_q[e] <= '0;
            len_q[e]  <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
            base_q[e] <= wr_base_i & ALIGN_MASK;
            len_q[e]  <= wr_len_i;
         end
      end
   end

   if ((1 << IDX_W) == ENTRIES) begin : g_full_index
      assign rd_base_o = base_q[rd_idx_i];
      assign rd_len_o  = len_q[rd_idx_i];
   end else begin : g_partial_index
      assign rd_base_o = (int'(rd_idx_i) < ENTRIES) ? base_q[rd_idx_i] : '0;
      assign rd_len_o  = (int'(rd_idx_i) < ENTRIES) ? len_q[rd_idx_i]  : '0;
   end

endmodule

// File: rtl/cil_word_fifo.sv
module cil_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic [W-1:0]     wdata_i,
   input  logic             pop_i,
   output logic [W-1:0]     rdata_o,
   output logic [CNT_W-1:0] count_o,
   output logic             empty_o
);

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count_q;
   logic             full, do_push, do_pop;

   assign full    = (count_q == CNT_W'(DEPTH));
   assign empty_o = (count_q == '0);
   assign do_push = push_i && !full && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr_q + PTR_W'(1);
      assign rd_nxt = rd_ptr_q + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
   end

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wr_ptr_q] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || flush_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_nxt;
         if (do_pop)  rd_ptr_q <= rd_nxt;
         count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   assign rdata_o = mem_q[rd_ptr_q];
   assign count_o = count_q;

endmodule

// File: rtl/cil_burst_reader.sv
module cil_burst_reader
   import cil_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int DATA_W = 32,
   parameter int BURST  = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int BW    = $clog2(BURST + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              launch_i,
   input  logic [ADDR_W-1:0] launch_base_i,
   input  logic [LEN_W-1:0]  launch_len_i,
   input  logic [CNT_W-1:0]  fifo_count_i,
   output logic [ADDR_W-1:0] haddr_o,
   output logic [1:0]        htrans_o,
   output logic [2:0]        hburst_o,
   input  logic [DATA_W-1:0] hrdata_i,
   input  logic              hready_i,
   input  logic              hresp_i,
   output logic              push_o,
   output logic [DATA_W-1:0] push_data_o,
   output logic              bus_err_o
);

   localparam logic [2:0] FULL_CODE = burst_code(BURST);

   logic [ADDR_W-1:0] iss_addr_q;
   logic [LEN_W-1:0]  iss_left_q;
   logic [BW-1:0]     bst_left_q;
   logic              bst_first_q;
   logic [2:0]        hburst_q;
   logic              dp_valid_q;
   logic [CNT_W-1:0]  resv_q;

   logic          err_now, data_ok, addr_active, accept, room, start_burst;
   logic [BW-1:0] nb;
   htrans_e       htrans;

   always_comb begin
      err_now     = dp_valid_q && hready_i && hresp_i;
      data_ok     = dp_valid_q && hready_i && !hresp_i;
      addr_active = (bst_left_q != '0) && !err_now;
      htrans      = addr_active ? (bst_first_q ? HT_NONSEQ : HT_SEQ) : HT_IDLE;
      accept      = addr_active && hready_i;
      room        = (int'(fifo_count_i) + int'(resv_q) + BURST) <= DEPTH;
      nb          = (iss_left_q >= LEN_W'(BURST)) ? BW'(BURST) : iss_left_q[BW-1:0];
      start_burst = (bst_left_q == '0) && (iss_left_q != '0) && room && !err_now;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         iss_addr_q  <= '0;
         iss_left_q  <= '0;
         bst_left_q  <= '0;
         bst_first_q <= 1'b0;
         hburst_q    <= HB_INCR;
         dp_valid_q  <= 1'b0;
         resv_q      <= '0;
      end else if (launch_i) begin
         iss_addr_q <= launch_base_i;
         iss_left_q <= launch_len_i;
         bst_left_q <= '0;
         dp_valid_q <= 1'b0;
         resv_q     <= '0;
      end else if (err_now) begin
         iss_left_q <= '0;
         bst_left_q <= '0;
         dp_valid_q <= 1'b0;
         resv_q     <= '0;
      end else begin
         if (accept) begin
            iss_addr_q  <= iss_addr_q + ADDR_W'(4);
            iss_left_q  <= iss_left_q - LEN_W'(1);
            bst_left_q  <= bst_left_q - BW'(1);
            bst_first_q <= 1'b0;
            dp_valid_q  <= 1'b1;
         end else if (hready_i) begin
            dp_valid_q <= 1'b0;
         end
         if (start_burst) begin
            bst_left_q  <= nb;
            bst_first_q <= 1'b1;
            hburst_q    <= (nb == BW'(BURST)) ? FULL_CODE : HB_INCR;
         end
         resv_q <= resv_q + (start_burst ? CNT_W'(nb) : '0) - CNT_W'(data_ok);
      end
   end

   assign haddr_o     = iss_addr_q;
   assign htrans_o    = htrans;
   assign hburst_o    = hburst_q;
   assign push_o      = data_ok;
   assign push_data_o = hrdata_i;
   assign bus_err_o   = err_now;

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cil_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int DATA_W     = 32,
   parameter int ENTRIES    = 4,
   parameter int FIFO_DEPTH = 16,
   parameter int BURST_LEN  = 8,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tbl_we_i,
   input  logic [IDX_W-1:0]  tbl_idx_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic [LEN_W-1:0]  tbl_len_i,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  start_idx_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] haddr_o,
   output logic [1:0]        htrans_o,
   output logic [2:0]        hburst_o,
   input  logic [DATA_W-1:0] hrdata_i,
   input  logic              hready_i,
   input  logic              hresp_i,
   output logic              cfg_valid_o,
   input  logic              cfg_ready_i,
   output logic [DATA_W-1:0] cfg_data_o
);

   if (DATA_W != 32) begin : g_bad_width
      $error("configuration port must be 32 bits wide");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("descriptor table needs at least two entries");
   end
   if (BURST_LEN < 1 || FIFO_DEPTH < BURST_LEN || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("buffer must hold at least one whole burst");
   end
   if (LEN_W < $clog2(BURST_LEN + 1) || ADDR_W < 3) begin : g_bad_fields
      $error("length or address field too narrow");
   end

   ld_state_e         state_q;
   logic [LEN_W-1:0]  len_q, wr_cnt_q;
   logic              done_q, err_q;

   logic [ADDR_W-1:0] sel_base;
   logic [LEN_W-1:0]  sel_len;
   logic              start_ok, launch, pop, fifo_empty;
   logic              fifo_push, bus_err;
   logic [DATA_W-1:0] fifo_wdata;
   logic [CNT_W-1:0]  fifo_cnt;

   cil_desc_table #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W)
   ) table_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (tbl_we_i),
      .wr_idx_i  (tbl_idx_i),
      .wr_base_i (tbl_base_i),
      .wr_len_i  (tbl_len_i),
      .rd_idx_i  (start_idx_i),
      .rd_base_o (sel_base),
      .rd_len_o  (sel_len)
   );

   assign start_ok = start_i && (state_q == LD_IDLE);
   assign launch   = start_ok && (sel_len != '0);
   assign pop      = cfg_valid_o && cfg_ready_i;

   cil_burst_reader #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .DATA_W (DATA_W),
      .BURST  (BURST_LEN),
      .DEPTH  (FIFO_DEPTH)
   ) reader_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .launch_i      (launch),
      .launch_base_i (sel_base),
      .launch_len_i  (sel_len),
      .fifo_count_i  (fifo_cnt),
      .haddr_o       (haddr_o),
      .htrans_o      (htrans_o),
      .hburst_o      (hburst_o),
      .hrdata_i      (hrdata_i),
      .hready_i      (hready_i),
      .hresp_i       (hresp_i),
      .push_o        (fifo_push),
      .push_data_o   (fifo_wdata),
      .bus_err_o     (bus_err)
   );

   cil_word_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) buffer_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (bus_err),
      .push_i  (fifo_push),
      .wdata_i (fifo_wdata),
      .pop_i   (pop),
      .rdata_o (cfg_data_o),
      .count_o (fifo_cnt),
      .empty_o (fifo_empty)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= LD_IDLE;
         len_q    <= '0;
         wr_cnt_q <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_ok) begin
            err_q <= 1'b0;
            if (sel_len == '0) begin
               done_q <= 1'b1;
            end else begin
               state_q  <= LD_RUN;
               len_q    <= sel_len;
               wr_cnt_q <= '0;
            end
         end else if (state_q == LD_RUN) begin
            if (bus_err) begin
               state_q <= LD_IDLE;
               done_q  <= 1'b1;
               err_q   <= 1'b1;
            end else if (pop) begin
               wr_cnt_q <= wr_cnt_q + LEN_W'(1);
               if (wr_cnt_q == len_q - LEN_W'(1)) begin
                  state_q <= LD_IDLE;
                  done_q  <= 1'b1;
               end
            end
         end
      end
   end

   assign busy_o      = (state_q == LD_RUN);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign cfg_valid_o = !fifo_empty;

endmodule

// File: rtl/cil_checks.sv
module cil_checks #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [ADDR_W-1:0] haddr_o,
   input logic [1:0]        htrans_o,
   input logic              hready_i,
   input logic              cfg_valid_o,
   input logic              cfg_ready_i,
   input logic [DATA_W-1:0] cfg_data_o,
   input logic              fifo_push,
   input logic [CNT_W-1:0]  fifo_cnt
);

   p_seq_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(htrans_o != 2'b00 && hready_i) && htrans_o == 2'b11)
      |-> haddr_o == $past(haddr_o) + ADDR_W'(4));

   p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_push |-> fifo_cnt < CNT_W'(DEPTH));

   p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_valid_o && !cfg_ready_i)
      |=> (cfg_valid_o && $stable(cfg_data_o)) || done_o);

   p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_idle_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> htrans_o == 2'b00);

   p_err_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> done_o);

   p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (htrans_o != 2'b00 && !hready_i)
      |=> htrans_o == $past(htrans_o) && $stable(haddr_o));

endmodule

bind cfg_image_loader cil_checks #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .DEPTH  (FIFO_DEPTH),
   .CNT_W  (CNT_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .haddr_o     (haddr_o),
   .htrans_o    (htrans_o),
   .hready_i    (hready_i),
   .cfg_valid_o (cfg_valid_o),
   .cfg_ready_i (cfg_ready_i),
   .cfg_data_o  (cfg_data_o),
   .fifo_push   (fifo_push),
   .fifo_cnt    (fifo_cnt)
);

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [1:0]    tbl_idx = '0;
   logic [AW-1:0] tbl_base = '0;
   logic [LW-1:0] tbl_len = '0;
   logic          start = 1'b0;
   logic [1:0]    start_idx = '0;
   logic          busy, done, err;
   logic [AW-1:0] haddr;
   logic [1:0]    htrans;
   logic [2:0]    hburst;
   logic [31:0]   hrdata;
   logic          hready, hresp;
   logic          cfg_valid;
   logic          cfg_ready = 1'b1;
   logic [31:0]   cfg_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int hs_cnt = 0, beat_cnt = 0, nb8_cnt = 0, nbi_cnt = 0, done_cnt = 0;
   bit err_at_done = 1'b0;

   logic [31:0] exp_q [$];
   logic [AW-1:0] m_base [4];
   logic [LW-1:0] m_len [4];

   bit bus_stall = 1'b0, cfg_rand = 1'b0, cfg_hold = 1'b0, err_en = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic rnd_rdy = 1'b1;

   cfg_image_loader dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_base_i(tbl_base), .tbl_len_i(tbl_len),
      .start_i(start), .start_idx_i(start_idx),
      .busy_o(busy), .done_o(done), .err_o(err),
      .haddr_o(haddr), .htrans_o(htrans), .hburst_o(hburst),
      .hrdata_i(hrdata), .hready_i(hready), .hresp_i(hresp),
      .cfg_valid_o(cfg_valid), .cfg_ready_i(cfg_ready), .cfg_data_o(cfg_data)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] mem_word(logic [AW-1:0] a);
      return {a[17:2] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   // memory slave with pipelined address and data phases
   logic          dp_v = 1'b0;
   logic [AW-1:0] dp_a = '0;
   always @(posedge clk) begin
      if (!rst_n) dp_v <= 1'b0;
      else if (hready) begin
         dp_v <= htrans[1];
         dp_a <= haddr;
      end
   end
   assign hready = !dp_v || rnd_rdy;
   assign hrdata = mem_word(dp_a);
   assign hresp  = dp_v && err_en && (dp_a == err_addr);

   always @(posedge clk) begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rnd_rdy   <= bus_stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      cfg_ready <= cfg_hold ? 1'b0 : (cfg_rand ? (lfsr[5] | lfsr[8]) : 1'b1);
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard compare and bus observation
   always @(negedge clk) begin
      cyc++;
      if (cfg_valid && cfg_ready) begin
         hs_cnt++;
         if (exp_q.size() == 0) chk(1'b0, "R1 unexpected word", cfg_data, 0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(cfg_data == e, "R1 word data", cfg_data, e);
         end
      end
      if (htrans != 2'b00 && hready) begin
         beat_cnt++;
         if (htrans == 2'b10 && hburst == 3'b101) nb8_cnt++;
         if (htrans == 2'b10 && hburst == 3'b001) nbi_cnt++;
      end
      if (done) begin
         done_cnt++;
         err_at_done = err;
      end
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tbl_write(input int idx, input logic [AW-1:0] base, input logic [LW-1:0] len);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_base = base; tbl_len = len;
      m_base[idx] = base & ~32'h3; m_len[idx] = len;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic pulse_start(input int idx);
      @(negedge clk);
      start = 1'b1; start_idx = 2'(idx);
      @(negedge clk);
      start = 1'b0;
   endtask

   // driver: pushes the expected words, then requests the copy
   task automatic start_img(input int idx);
      for (int i = 0; i < int'(m_len[idx]); i++) exp_q.push_back(mem_word(m_base[idx] + AW'(4 * i)));
      pulse_start(idx);
   endtask

   task automatic wait_done(input int d0, input string tag);
      int t = 0;
      while (done_cnt == d0 && t < 5000) begin
         @(posedge clk);
         t++;
      end
      chk(done_cnt == d0 + 1, tag, done_cnt, d0 + 1);
   endtask

   initial begin
      int d0, h0, b0, n8, ni;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({busy, done, err, cfg_valid} == 4'b0, "R10 flags after reset", {busy, done, err, cfg_valid}, 0);
      chk(htrans == 2'b00, "R10 bus idle after reset", htrans, 0);

      tbl_write(0, 32'h0000_1000, 16'd20);
      tbl_write(1, 32'h0000_2042, 16'd37);
      tbl_write(2, 32'h0000_4000, 16'd40);
      tbl_write(3, 32'h0000_6000, 16'd0);

      // R1 R2 R5: plain copy, split into full and short bursts
      d0 = done_cnt; h0 = hs_cnt; n8 = nb8_cnt; ni = nbi_cnt;
      start_img(0);
      wait_done(d0, "R5 done after copy");
      @(negedge clk);
      chk(!done && !busy, "R5 done one cycle, busy low", {done, busy}, 0);
      chk(hs_cnt - h0 == 20, "R1 word count", hs_cnt - h0, 20);
      chk(nb8_cnt - n8 == 2, "R2 full bursts", nb8_cnt - n8, 2);
      chk(nbi_cnt - ni == 1, "R2 short bursts", nbi_cnt - ni, 1);
      chk(exp_q.size() == 0, "R1 all words seen", exp_q.size(), 0);

      // R9: random wait states on bus and port
      bus_stall = 1'b1; cfg_rand = 1'b1;
      d0 = done_cnt; h0 = hs_cnt;
      start_img(1);
      wait_done(d0, "R9 done under stalls");
      chk(hs_cnt - h0 == 37, "R9 word count under stalls", hs_cnt - h0, 37);
      chk(exp_q.size() == 0, "R9 all words seen", exp_q.size(), 0);
      bus_stall = 1'b0; cfg_rand = 1'b0;

      // R3 R4: port held off, then released
      @(negedge clk); cfg_hold = 1'b1;
      repeat (2) @(negedge clk);
      d0 = done_cnt; h0 = hs_cnt; b0 = beat_cnt;
      start_img(2);
      repeat (200) @(negedge clk);
      chk(beat_cnt - b0 == 16, "R3 beats while port blocked", beat_cnt - b0, 16);
      chk(cfg_valid == 1'b1, "R4 valid while blocked", cfg_valid, 1);
      cfg_hold = 1'b0;
      @(posedge clk);
      h0 = hs_cnt;
      repeat (16) @(posedge clk);
      chk(hs_cnt - h0 == 16, "R4 one word per cycle", hs_cnt - h0, 16);
      wait_done(d0, "R3 done after release");
      chk(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);

      // R6: zero length entry
      @(negedge clk);
      d0 = done_cnt; b0 = beat_cnt;
      start_img(3);
      chk(busy == 1'b0, "R6 busy stays low", busy, 0);
      @(posedge clk);
      chk(done_cnt == d0 + 1, "R6 immediate done", done_cnt, d0 + 1);
      repeat (5) @(negedge clk);
      chk(beat_cnt == b0, "R6 no bus transfer", beat_cnt, b0);

      // R7: start while busy is ignored
      d0 = done_cnt; h0 = hs_cnt;
      start_img(0);
      repeat (3) @(negedge clk);
      pulse_start(1);
      wait_done(d0, "R7 done once");
      repeat (40) @(negedge clk);
      chk(done_cnt == d0 + 1, "R7 single done", done_cnt, d0 + 1);
      chk(hs_cnt - h0 == 20, "R7 original image only", hs_cnt - h0, 20);
      chk(exp_q.size() == 0, "R7 all words seen", exp_q.size(), 0);

      // R8: bus error on the eleventh beat
      err_en = 1'b1; err_addr = m_base[1] + 32'd40;
      d0 = done_cnt; h0 = hs_cnt;
      start_img(1);
      wait_done(d0, "R8 done on error");
      chk(err_at_done == 1'b1, "R8 error flag with done", err_at_done, 1);
      @(negedge clk);
      b0 = beat_cnt;
      chk(cfg_valid == 1'b0, "R8 buffer emptied", cfg_valid, 0);
      repeat (20) @(negedge clk);
      chk(beat_cnt == b0, "R8 no transfers after abort", beat_cnt, b0);
      chk(hs_cnt - h0 <= 10, "R8 words before error", hs_cnt - h0, 10);
      chk(err == 1'b1, "R8 error flag holds", err, 1);
      exp_q.delete();
      err_en = 1'b0;

      // R1 R8: rewritten descriptor, error flag cleared on start
      tbl_write(0, 32'h0000_8000, 16'd9);
      d0 = done_cnt; h0 = hs_cnt;
      start_img(0);
      @(negedge clk);
      chk(err == 1'b0, "R8 error cleared by start", err, 0);
      wait_done(d0, "R1 done after rewrite");
      chk(hs_cnt - h0 == 9, "R1 rewritten length", hs_cnt - h0, 9);
      chk(exp_q.size() == 0, "R1 rewritten words seen", exp_q.size(), 0);

      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule